// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is an eight-bit execution datapath steered by a 14-bit control word that arrives every clock. The word names two operand sources, one destination and a five-bit operation. A shared ALU combines the two operands. On a rising edge where the strobe `valid` is high and the operation is one the ALU knows, the result is stored in the destination register. The result bus shows the ALU output in the same cycle as the control word.

There are seven general registers, numbered 1 to 7. Source number 0 does not name a register; it feeds the external data input into that ALU port, which is how values are loaded. Destination number 0 means the operation runs without storing anything. The ALU decodes only five sparse operation codes. Every other code is a no-op: it is flagged as illegal and has no effect on any state. A carry flag and a zero flag describe the last operation that was carried out. A separate view port shows any register without disturbing the datapath.

Top module: `ctrl_datapath`

## Requirements
- R1: The control word is split from its most significant bit as source A [13:11], source B [10:8], destination [7:5] and operation [4:0]. Code 10010 gives A plus B modulo 256, which is written to the destination register at the rising edge.
- R2: Operation code 00000 passes source A unchanged to the result bus and to the destination register.
- R3: Operation code 01011 gives the bitwise OR of A and B. Operation code 10001 gives their bitwise AND.
- R4: Operation code 10100 gives the one's complement of A.
- R5: A source select of 000 feeds `ext_data` to that ALU port. Select values 1 to 7 feed the register with that number.
- R6: A destination select of 000 leaves all registers unchanged, while the result still appears on `result`.
- R7: Any other operation code drives `result` to 0, writes no register, leaves both flags unchanged, and raises `illegal_op` in that cycle while `valid` is high.
- R8: While `valid` is low, no register and no flag changes.
- R9: A synchronous reset clears all seven registers and both flags to 0.
- R10: After a valid legal operation, `carry_flag` holds the carry out of the add for code 10010 and 0 for the other legal codes. `zero_flag` is 1 exactly when that result was 0.
- R11: `view_data` shows register `view_sel` combinationally for values 1 to 7, and shows 0 for `view_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 14 | Control word: source A, source B, destination, operation |
| ext_data | input | 8 | External operand, selected by source code 000 |
| valid | input | 1 | Control word is to be executed at this edge |
| view_sel | input | 3 | Register number shown on view_data |
| result | output | 8 | Combinational ALU result |
| view_data | output | 8 | Contents of the register selected by view_sel |
| illegal_op | output | 1 | Unknown operation code while valid |
| carry_flag | output | 1 | Carry out of the last executed add |
| zero_flag | output | 1 | The last executed result was zero |

## Verification
`result` and `illegal_op` are combinational. The bench samples them one nanosecond after it drives a control word on the falling edge, which is before the edge that executes the word. Register contents and both flags are due one rising edge after execution. The bench reads them through `view_sel` during the low half of the following cycle. While it reads, `valid` is held low, so no write can happen between the stimulus and the check. The bench model is updated only at the executing edge, so every comparison is aligned to that single register stage.

// File: rtl/dp_pkg.sv
package dp_pkg;
    localparam int SEL_W  = 3;
    localparam int OPC_W  = 5;
    localparam int CTL_W  = 3 * SEL_W + OPC_W;
    localparam int NUM_RG = (1 << SEL_W) - 1;

    localparam logic [OPC_W-1:0] OPC_PASS = 5'b00000;
    localparam logic [OPC_W-1:0] OPC_OR   = 5'b01011;
    localparam logic [OPC_W-1:0] OPC_ADD  = 5'b10010;
    localparam logic [OPC_W-1:0] OPC_AND  = 5'b10001;
    localparam logic [OPC_W-1:0] OPC_INV  = 5'b10100;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OPC_W-1:0] opc;
    } ctl_fields_t;

    typedef struct packed {
        logic carry;
        logic zero;
    } flags_t;
endpackage

// File: rtl/dp_decode.sv
module dp_decode
    import dp_pkg::*;
(
    input  logic [CTL_W-1:0] ctl_word,
    output ctl_fields_t      fields,
    output logic             legal
);
    always_comb begin
        fields = ctl_fields_t'(ctl_word);
        unique case (fields.opc)
            OPC_PASS, OPC_OR, OPC_ADD, OPC_AND, OPC_INV: legal = 1'b1;
            default:                                     legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [OPC_W-1:0]  opc,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    logic [DATA_W:0] sum_w;

    always_comb begin
        sum_w = {1'b0, op_a} + {1'b0, op_b};
        res   = '0;
        cout  = 1'b0;
        case (opc)
            OPC_PASS: res = op_a;
            OPC_OR:   res = op_a | op_b;
            OPC_AND:  res = op_a & op_b;
            OPC_INV:  res = ~op_a;
            OPC_ADD: begin
                res  = sum_w[DATA_W-1:0];
                cout = sum_w[DATA_W];
            end
            default: begin
                res  = '0;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
    import dp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_a_sel,
    input  logic [SEL_W-1:0]  rd_b_sel,
    input  logic [SEL_W-1:0]  view_sel,
    input  logic [DATA_W-1:0] ext_data,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    output logic [DATA_W-1:0] view_data
);
    localparam int TBL_N = NUM_RG + 1;

    logic [NUM_RG-1:0][DATA_W-1:0] regs_d, regs_q;
    logic [DATA_W-1:0] src_tbl  [TBL_N];
    logic [DATA_W-1:0] view_tbl [TBL_N];

    assign src_tbl[0]  = ext_data;
    assign view_tbl[0] = '0;
    for (genvar g = 1; g < TBL_N; g++) begin : g_tbl
        assign src_tbl[g]  = regs_q[g-1];
        assign view_tbl[g] = regs_q[g-1];
    end

    assign rd_a      = src_tbl[rd_a_sel];
    assign rd_b      = src_tbl[rd_b_sel];
    assign view_data = view_tbl[view_sel];

    always_comb begin
        regs_d = regs_q;
        for (int i = 1; i <= NUM_RG; i++) begin
            if (wr_en && (wr_sel == SEL_W'(i))) regs_d[i-1] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    // R8: nothing is stored on an edge without a write enable
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));
    // R6: destination 0 stores nowhere
    a_r6_dst_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == '0) |=> $stable(regs_q));
    // R9: reset empties the file
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (regs_q == '0));
endmodule

// File: rtl/ctrl_datapath.sv
module ctrl_datapath
    import dp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTL_W-1:0]  ctl_word,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              valid,
    input  logic [SEL_W-1:0]  view_sel,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] view_data,
    output logic              illegal_op,
    output logic              carry_flag,
    output logic              zero_flag
);
    ctl_fields_t       fld;
    logic              legal;
    logic [DATA_W-1:0] opnd_a, opnd_b, alu_y;
    logic              alu_c;
    logic              exec;
    flags_t            flags_d, flags_q;

    dp_decode u_dec (
        .ctl_word (ctl_word),
        .fields   (fld),
        .legal    (legal)
    );

    dp_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (exec),
        .wr_sel    (fld.dst),
        .wr_data   (alu_y),
        .rd_a_sel  (fld.src_a),
        .rd_b_sel  (fld.src_b),
        .view_sel  (view_sel),
        .ext_data  (ext_data),
        .rd_a      (opnd_a),
        .rd_b      (opnd_b),
        .view_data (view_data)
    );

    dp_alu #(.DATA_W(DATA_W)) u_alu (
        .op_a (opnd_a),
        .op_b (opnd_b),
        .opc  (fld.opc),
        .res  (alu_y),
        .cout (alu_c)
    );

    always_comb begin
        exec    = valid && legal;
        flags_d = flags_q;
        if (exec) begin
            flags_d.carry = alu_c;
            flags_d.zero  = (alu_y == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign result     = alu_y;
    assign illegal_op = valid && !legal;
    assign carry_flag = flags_q.carry;
    assign zero_flag  = flags_q.zero;

    // R7: a rejected code leaves the flags as they were
    a_r7_illegal_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        illegal_op |=> $stable(flags_q));
    // R7: a rejected code shows zero on the result bus
    a_r7_illegal_result_zero: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (result == '0));
    // R8: idle cycles leave the flags as they were
    a_r8_idle_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(flags_q));
    // R10: carry only survives an add
    a_r10_carry_add_only: assert property (@(posedge clk) disable iff (rst)
        (valid && legal && fld.opc != OPC_ADD) |=> !carry_flag);
    // R10: zero flag follows the executed result
    a_r10_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        (valid && legal) |=> (zero_flag == ($past(result) == '0)));
    // R4: complement yields the inverse of operand A
    a_r4_invert: assert property (@(posedge clk) disable iff (rst)
        (fld.opc == OPC_INV) |-> ((result ^ opnd_a) == '1));
    // R2: transfer reproduces operand A
    a_r2_pass: assert property (@(posedge clk) disable iff (rst)
        (fld.opc == OPC_PASS) |-> (result == opnd_a));
endmodule

// File: tb/test_ctrl_datapath.sv
`timescale 1ns/100ps
module test_ctrl_datapath;
    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] ctl_word;
    logic [7:0]  ext_data;
    logic        valid;
    logic [2:0]  view_sel;
    logic [7:0]  result, view_data;
    logic        illegal_op, carry_flag, zero_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_reg [1:7];
    logic       m_c, m_z;

    always #4 clk = ~clk;

    ctrl_datapath i_ctrl_datapath (
        .clk(clk), .rst(rst), .ctl_word(ctl_word), .ext_data(ext_data),
        .valid(valid), .view_sel(view_sel), .result(result),
        .view_data(view_data), .illegal_op(illegal_op),
        .carry_flag(carry_flag), .zero_flag(zero_flag)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_legal(input logic [4:0] op);
        return op == 5'b00000 || op == 5'b01011 || op == 5'b10010 ||
               op == 5'b10001 || op == 5'b10100;
    endfunction

    function automatic logic [8:0] model_alu(input logic [4:0] op,
                                             input logic [7:0] a, input logic [7:0] b);
        case (op)
            5'b00000: return {1'b0, a};
            5'b01011: return {1'b0, a | b};
            5'b10001: return {1'b0, a & b};
            5'b10100: return {1'b0, ~a};
            5'b10010: return {1'b0, a} + {1'b0, b};
            default:  return 9'h000;
        endcase
    endfunction

    function automatic string op_tag(input logic [4:0] op);
        case (op)
            5'b10010: return "R1";
            5'b00000: return "R2";
            5'b01011, 5'b10001: return "R3";
            5'b10100: return "R4";
            default:  return "R7";
        endcase
    endfunction

    function automatic logic [7:0] src_val(input logic [2:0] s, input logic [7:0] e);
        return (s == 3'd0) ? e : m_reg[s];
    endfunction

    task automatic apply(input logic [13:0] w, input logic [7:0] e, input logic v);
        logic [8:0] exp;
        @(negedge clk);
        ctl_word = w; ext_data = e; valid = v;
        #1;
        exp = model_alu(w[4:0], src_val(w[13:11], e), src_val(w[10:8], e));
        chk(op_tag(w[4:0]), {1'b0, result}, {1'b0, exp[7:0]});
        chk("R7", {8'd0, illegal_op}, {8'd0, v && !is_legal(w[4:0])});
        @(posedge clk);
        if (v && is_legal(w[4:0])) begin
            if (w[7:5] != 3'd0) m_reg[w[7:5]] = exp[7:0];
            m_c = (w[4:0] == 5'b10010) ? exp[8] : 1'b0;
            m_z = (exp[7:0] == 8'd0);
        end
    endtask

    task automatic check_state(input string tag);
        @(negedge clk);
        valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            view_sel = 3'(i);
            #0.4;
            chk((i == 0) ? "R11" : tag, {1'b0, view_data},
                {1'b0, (i == 0) ? 8'd0 : m_reg[i]});
        end
        chk("R10", {7'd0, carry_flag, zero_flag}, {7'd0, m_c, m_z});
    endtask

    task automatic model_clear();
        for (int i = 1; i <= 7; i++) m_reg[i] = 8'd0;
        m_c = 1'b0; m_z = 1'b0;
    endtask

    function automatic logic [13:0] cw(input int sa, input int sb, input int sd,
                                       input logic [4:0] op);
        return {3'(sa), 3'(sb), 3'(sd), op};
    endfunction

    initial begin
        #1200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] ops [5];
        ops[0] = 5'b00000; ops[1] = 5'b01011; ops[2] = 5'b10010;
        ops[3] = 5'b10001; ops[4] = 5'b10100;
        void'($urandom(32'd2024));
        rst = 1'b1; ctl_word = '0; ext_data = '0; valid = 1'b0; view_sel = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check_state("R9");

        // R5 and R2: load every register from the external input
        for (int n = 1; n <= 7; n++) begin
            apply(cw(0, 0, n, 5'b00000), 8'(n * 8'h21), 1'b1);
            check_state("R5");
        end
        // R1: R4 <- R2 + R3 using the field layout
        apply(14'b010_011_100_10010, 8'h00, 1'b1);
        check_state("R1");
        // R10: sum wraps to zero with a carry out
        apply(cw(0, 0, 5, 5'b00000), 8'h80, 1'b1);
        apply(cw(5, 0, 6, 5'b10010), 8'h80, 1'b1);
        check_state("R10");
        // R3 and R4
        apply(cw(1, 2, 7, 5'b01011), 8'h00, 1'b1);
        check_state("R3");
        apply(cw(3, 4, 7, 5'b10001), 8'h00, 1'b1);
        check_state("R3");
        apply(cw(7, 0, 1, 5'b10100), 8'h00, 1'b1);
        check_state("R4");
        // R6: destination zero stores nothing
        apply(cw(2, 3, 0, 5'b10010), 8'h00, 1'b1);
        check_state("R6");
        // R7: unknown codes
        apply(cw(1, 2, 3, 5'b11111), 8'hFF, 1'b1);
        check_state("R7");
        apply(cw(0, 0, 4, 5'b00001), 8'h5A, 1'b1);
        check_state("R7");
        // R8: strobe low
        apply(cw(0, 0, 2, 5'b00000), 8'hC3, 1'b0);
        check_state("R8");
        // R9: reset in the middle of a run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_clear();
        check_state("R9");

        for (int k = 0; k < 400; k++) begin
            logic [4:0] op;
            op = ($urandom % 5 != 0) ? ops[$urandom % 5] : 5'($urandom);
            apply(cw($urandom % 8, $urandom % 8, $urandom % 8, op),
                  8'($urandom), ($urandom % 10) != 0);
            if (k % 4 == 3) check_state("R1");
        end
        check_state("R11");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule